// File: doc/BRIEF.md
# SCSI Controller Register and Interrupt File

This block is the byte-wide register file of a simple SCSI protocol controller, seen by a host processor through a memory-mapped window in which each register occupies a 4-byte slot. It keeps two register banks. Writes always land in the write bank. Reads come from a separate read bank, which holds the 16-bit transfer counter, status, interrupt cause, sequence step and a fixed revision byte. Only selected writes reach the read bank. A small data FIFO sits behind one register. The block drives a single level-sensitive interrupt line.

Writing the command register decodes a small opcode set: no-operation, FIFO flush, chip reset, bus reset and target selection. The top bit of the command is a DMA flag that reloads the readable transfer counter from the bytes last written. Target selection checks a stub vector of present targets and reports either a completed selection or a disconnect.

Reads have side effects. Reading the interrupt register acknowledges the interrupt. Reading the FIFO register pops a byte and signals an interrupt.

Top module: `scsi_regfile`

## Requirements
- R1: After reset, `irq` is 0, every register reads 0x00 except index 14, which reads 0x04, and the FIFO is empty. The register index is `bus_addr[5:2]`, and `bus_addr[1:0]` has no effect.
- R2: A write stores its byte in the write bank only. Read-bank indices 0 (counter low byte) and 1 (counter high byte) keep their values. The exception is a write to index 3 (command), which also becomes readable at index 3.
- R3: A command byte with bit 7 set copies write-bank bytes 0 and 1 into read indices 0 and 1. These are the values held before that cycle.
- R4: Every command write clears status bit 4 (terminal count) at read index 4 before the opcode acts.
- R5: A read of index 5 (interrupt cause) clears status bits 7, 6 and 5 and drops `irq` on the next edge. A read of index 5 does not itself change index 5.
- R6: Opcode 0x03 (bus reset, command bits 6:0) writes 0x80 to index 5. It raises `irq` only when bit 6 of write-bank index 8 (configuration) is 0.
- R7: Opcode 0x01 (flush) empties the FIFO and writes 0x08 to index 5 without changing `irq`.
- R8: Opcode 0x02 (chip reset) clears both banks, empties the FIFO, drops `irq` and reloads 0x04 into read index 14. It overrides the DMA flag.
- R9: Opcode 0x41 (select) takes the target ID from write-bank index 4 bits 2:0. If the ID is 7 or its `tgt_present` bit is 0, it sets status bit 7, writes 0x20 to index 5 and 0x00 to index 6. If the target is present, it sets status bits 7 and 4, writes 0x18 to index 5 and 0x04 to index 6. Both cases raise `irq`.
- R10: A write to index 2 pushes a byte unless the FIFO holds `FIFO_DEPTH` bytes, in which case the byte is dropped. A read of index 2 returns the oldest byte, pops it and raises `irq`. A read of index 2 while the FIFO is empty returns 0x00 and changes nothing.
- R11: `irq` is a level that stays set until an index-5 read or a chip or hardware reset clears it. A raise and a clear in the same cycle leave it set.
- R12: Opcode 0x00 and unknown opcodes change only status bit 4, the readable command copy and, when bit 7 is set, the counter bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe; triggers read side effects |
| bus_wdata | input | 8 | Write data |
| tgt_present | input | N_TGT | Stub: bit n set when target n responds to selection |
| bus_rdata | output | 8 | Read data from the read bank or FIFO head |
| irq | output | 1 | Level interrupt request |

## Verification
Directed sequences cover the counter reload and selection of a present target, an absent target and ID 7. They also cover bus reset with the configuration mask both clear and set, and filling the FIFO past its depth, so that each interrupt cause and each masking path is seen apart. A long constrained-random run then mixes reads and writes across all sixteen indices with random low address bits, DMA flags and opcodes. Read data and `irq` are compared every cycle against a bench model. This separates ordering faults: a read clear against a raise, a reload against a chip reset, and a bank mix-up that only shows when a later read follows an unrelated write.

// File: rtl/scsi_rf_pkg.sv
package scsi_rf_pkg;

    localparam int unsigned IDX_W = 4;
    localparam int unsigned NREG  = 1 << IDX_W;

    localparam logic [IDX_W-1:0] IX_CNT_LO = 4'd0;
    localparam logic [IDX_W-1:0] IX_CNT_HI = 4'd1;
    localparam logic [IDX_W-1:0] IX_FIFO   = 4'd2;
    localparam logic [IDX_W-1:0] IX_CMD    = 4'd3;
    localparam logic [IDX_W-1:0] IX_STAT   = 4'd4;   // write side: target id
    localparam logic [IDX_W-1:0] IX_CAUSE  = 4'd5;
    localparam logic [IDX_W-1:0] IX_STEP   = 4'd6;
    localparam logic [IDX_W-1:0] IX_CFG    = 4'd8;
    localparam logic [IDX_W-1:0] IX_REV    = 4'd14;

    localparam logic [7:0] REV_ID    = 8'h04;
    localparam logic [7:0] STEP_DONE = 8'h04;

    localparam int unsigned ST_INT = 7;
    localparam int unsigned ST_GE  = 6;
    localparam int unsigned ST_PE  = 5;
    localparam int unsigned ST_TC  = 4;

    localparam logic [7:0] CZ_BUSRST = 8'h80;
    localparam logic [7:0] CZ_DISC   = 8'h20;
    localparam logic [7:0] CZ_SVC    = 8'h10;
    localparam logic [7:0] CZ_DONE   = 8'h08;

    localparam int unsigned CFG_NOIRQ_BIT = 6;

    typedef enum logic [6:0] {
        OP_NOP    = 7'h00,
        OP_FLUSH  = 7'h01,
        OP_CHIPRS = 7'h02,
        OP_BUSRS  = 7'h03,
        OP_SELECT = 7'h41
    } op_e;

    typedef struct packed {
        logic dma;
        logic flush;
        logic chip_rst;
        logic bus_rst;
        logic sel_ok;
        logic sel_fail;
    } cmd_act_t;

    typedef struct packed {
        logic [NREG-1:0][7:0] rb;
        logic [NREG-1:0][7:0] wb;
        logic                 irq;
    } rf_state_t;

    function automatic rf_state_t rf_reset_state();
        rf_state_t s;
        s = '0;
        s.rb[IX_REV] = REV_ID;
        return s;
    endfunction

endpackage

// File: rtl/scsi_rf_fifo.sv
module scsi_rf_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         empty
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t f_d, f_q;
    logic     push_ok, pop_ok;

    always_comb begin
        f_d     = f_q;
        push_ok = push && (f_q.cnt != CW'(DEPTH));
        pop_ok  = pop && (f_q.cnt != '0);
        if (push_ok) begin
            f_d.mem[f_q.wp] = wdata;
            f_d.wp = (f_q.wp == PW'(DEPTH - 1)) ? '0 : f_q.wp + 1'b1;
        end
        if (pop_ok) begin
            f_d.rp = (f_q.rp == PW'(DEPTH - 1)) ? '0 : f_q.rp + 1'b1;
        end
        f_d.cnt = f_q.cnt + CW'(push_ok) - CW'(pop_ok);
        if (clr) begin
            f_d.wp  = '0;
            f_d.rp  = '0;
            f_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign rdata = f_q.mem[f_q.rp];
    assign empty = (f_q.cnt == '0);

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= CW'(DEPTH));                                                   // R10
    AST_FIFO_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && f_q.cnt == CW'(DEPTH)) |=> (f_q.cnt == CW'(DEPTH))); // R10

endmodule

// File: rtl/scsi_rf_cmd_dec.sv
module scsi_rf_cmd_dec
    import scsi_rf_pkg::*;
#(
    parameter int unsigned N_TGT = 7
) (
    input  logic [7:0]       cmd,
    input  logic [2:0]       tgt_id,
    input  logic [N_TGT-1:0] present,
    output cmd_act_t         act
);
    logic tgt_hit;

    always_comb begin
        tgt_hit = 1'b0;
        for (int i = 0; i < N_TGT; i++) begin
            if (tgt_id == 3'(i) && tgt_id != 3'd7) tgt_hit = present[i];
        end
    end

    always_comb begin
        act          = '0;
        act.dma      = cmd[7];
        act.flush    = (cmd[6:0] == OP_FLUSH);
        act.chip_rst = (cmd[6:0] == OP_CHIPRS);
        act.bus_rst  = (cmd[6:0] == OP_BUSRS);
        act.sel_ok   = (cmd[6:0] == OP_SELECT) && tgt_hit;
        act.sel_fail = (cmd[6:0] == OP_SELECT) && !tgt_hit;
    end

endmodule

// File: rtl/scsi_regfile.sv
module scsi_regfile
    import scsi_rf_pkg::*;
#(
    parameter int unsigned ADDR_W     = 6,
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned N_TGT      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    input  logic [N_TGT-1:0]  tgt_present,
    output logic [7:0]        bus_rdata,
    output logic              irq
);
    localparam int unsigned IDX_LSB = 2;

    rf_state_t        s_d, s_q;
    cmd_act_t         act;
    logic [IDX_W-1:0] idx;
    logic             set_irq, clr_irq;
    logic             fifo_push, fifo_pop, fifo_clr, fifo_empty;
    logic [7:0]       fifo_head;
    logic             unused_sink;

    assign idx = bus_addr[IDX_LSB +: IDX_W];

    scsi_rf_cmd_dec #(.N_TGT(N_TGT)) u_dec (
        .cmd     (bus_wdata),
        .tgt_id  (s_q.wb[IX_STAT][2:0]),
        .present (tgt_present),
        .act     (act)
    );

    scsi_rf_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .wdata (bus_wdata),
        .rdata (fifo_head),
        .empty (fifo_empty)
    );

    always_comb begin
        s_d       = s_q;
        set_irq   = 1'b0;
        clr_irq   = 1'b0;
        fifo_push = 1'b0;
        fifo_pop  = 1'b0;
        fifo_clr  = 1'b0;

        // read side effects first, so a same-cycle command wins
        if (bus_rd) begin
            if (idx == IX_CAUSE) begin
                s_d.rb[IX_STAT][ST_INT] = 1'b0;
                s_d.rb[IX_STAT][ST_GE]  = 1'b0;
                s_d.rb[IX_STAT][ST_PE]  = 1'b0;
                clr_irq = 1'b1;
            end
            if (idx == IX_FIFO && !fifo_empty) begin
                fifo_pop = 1'b1;
                set_irq  = 1'b1;
            end
        end

        if (bus_wr) begin
            s_d.wb[idx] = bus_wdata;
            if (idx == IX_FIFO) fifo_push = 1'b1;
            if (idx == IX_CMD) begin
                s_d.rb[IX_STAT][ST_TC] = 1'b0;
                s_d.rb[IX_CMD]         = bus_wdata;
                if (act.dma) begin
                    s_d.rb[IX_CNT_LO] = s_q.wb[IX_CNT_LO];
                    s_d.rb[IX_CNT_HI] = s_q.wb[IX_CNT_HI];
                end
                if (act.flush) begin
                    fifo_clr          = 1'b1;
                    s_d.rb[IX_CAUSE]  = CZ_DONE;
                end
                if (act.bus_rst) begin
                    s_d.rb[IX_CAUSE] = CZ_BUSRST;
                    if (!s_q.wb[IX_CFG][CFG_NOIRQ_BIT]) set_irq = 1'b1;
                end
                if (act.sel_ok) begin
                    s_d.rb[IX_STAT][ST_INT] = 1'b1;
                    s_d.rb[IX_STAT][ST_TC]  = 1'b1;
                    s_d.rb[IX_CAUSE]        = CZ_SVC | CZ_DONE;
                    s_d.rb[IX_STEP]         = STEP_DONE;
                    set_irq                 = 1'b1;
                end
                if (act.sel_fail) begin
                    s_d.rb[IX_STAT][ST_INT] = 1'b1;
                    s_d.rb[IX_CAUSE]        = CZ_DISC;
                    s_d.rb[IX_STEP]         = 8'h00;
                    set_irq                 = 1'b1;
                end
            end
        end

        if (set_irq)      s_d.irq = 1'b1;
        else if (clr_irq) s_d.irq = 1'b0;

        if (bus_wr && idx == IX_CMD && act.chip_rst) begin
            s_d      = rf_reset_state();
            fifo_clr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= rf_reset_state();
        else        s_q <= s_d;
    end

    assign bus_rdata   = (idx == IX_FIFO) ? (fifo_empty ? 8'h00 : fifo_head) : s_q.rb[idx];
    assign irq         = s_q.irq;
    assign unused_sink = ^{bus_addr, s_q.wb};

    AST_CAUSE_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && idx == IX_CAUSE && !bus_wr) |=> !irq);                                  // R5
    AST_DMA_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == IX_CMD && bus_wdata[7] && bus_wdata[6:0] != OP_CHIPRS)
        |=> (s_q.rb[IX_CNT_LO] == $past(s_q.wb[IX_CNT_LO]) &&
             s_q.rb[IX_CNT_HI] == $past(s_q.wb[IX_CNT_HI])));                              // R3
    AST_BUSRST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && idx == IX_CMD && bus_wdata[6:0] == OP_BUSRS &&
         s_q.wb[IX_CFG][CFG_NOIRQ_BIT] && !irq) |=> !irq);                                 // R6
    AST_CHIPRST_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == IX_CMD && bus_wdata[6:0] == OP_CHIPRS)
        |=> (!irq && s_q.rb[IX_REV] == REV_ID && fifo_empty));                             // R8
    AST_SELECT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == IX_CMD && bus_wdata[6:0] == OP_SELECT)
        |=> (irq && s_q.rb[IX_STAT][ST_INT]));                                              // R9
    AST_CMD_CLEARS_TC: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == IX_CMD && bus_wdata[6:0] != OP_SELECT) |=> !s_q.rb[IX_STAT][ST_TC]); // R4
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_rd && !(bus_wr && idx == IX_CMD)) |=> irq);                           // R11

endmodule

// File: tb/tb_scsi_regfile.sv
`timescale 1ns/1ps
module tb_scsi_regfile;
    localparam int    FDEPTH = 16;
    localparam logic [6:0] PRES = 7'b0100101;   // targets 0, 2, 5 present

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] bus_addr;
    logic       bus_wr, bus_rd;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] m_r [16];
    logic [7:0] m_w [16];
    logic [7:0] m_q [$];
    logic       m_irq;

    always #4 clk = ~clk;   // 125 MHz

    scsi_regfile dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .tgt_present(PRES),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            m_r[i] = 8'h00;
            m_w[i] = 8'h00;
        end
        m_r[14] = 8'h04;
        m_q.delete();
        m_irq = 1'b0;
    endtask

    function automatic logic [7:0] model_rd(input int idx);
        if (idx == 2) return (m_q.size() > 0) ? m_q[0] : 8'h00;
        return m_r[idx];
    endfunction

    task automatic model_step(input bit w, input bit r, input int idx, input logic [7:0] d);
        bit         raise = 0, lower = 0;
        logic [2:0] tid;
        bit         ok;
        if (r) begin
            if (idx == 5) begin m_r[4] = m_r[4] & 8'h1F; lower = 1; end
            if (idx == 2 && m_q.size() > 0) begin void'(m_q.pop_front()); raise = 1; end
        end
        if (w) begin
            m_w[idx] = d;
            if (idx == 2 && m_q.size() < FDEPTH) m_q.push_back(d);
            if (idx == 3) begin
                m_r[4] = m_r[4] & 8'hEF;
                m_r[3] = d;
                if (d[7]) begin m_r[0] = m_w[0]; m_r[1] = m_w[1]; end
                case (d[6:0])
                    7'h01: begin m_q.delete(); m_r[5] = 8'h08; end
                    7'h03: begin m_r[5] = 8'h80; if (!m_w[8][6]) raise = 1; end
                    7'h41: begin
                        tid = m_w[4][2:0];
                        ok  = (tid < 3'd7) ? PRES[tid] : 1'b0;
                        if (ok) begin m_r[4] = m_r[4] | 8'h90; m_r[5] = 8'h18; m_r[6] = 8'h04; end
                        else    begin m_r[4] = m_r[4] | 8'h80; m_r[5] = 8'h20; m_r[6] = 8'h00; end
                        raise = 1;
                    end
                    default: ;
                endcase
            end
        end
        if (raise)      m_irq = 1'b1;
        else if (lower) m_irq = 1'b0;
        if (w && idx == 3 && d[6:0] == 7'h02) model_reset();
    endtask

    // starts and ends at a falling edge
    task automatic op(input bit w, input bit r, input int idx, input logic [7:0] d,
                      input string req, input logic [1:0] lo = 2'b00);
        bus_wr    = w;
        bus_rd    = r;
        bus_addr  = {idx[3:0], lo};
        bus_wdata = d;
        #1;
        if (r) check(req, bus_rdata, model_rd(idx));
        model_step(w, r, idx, d);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        check(req, {7'b0, irq}, {7'b0, m_irq});
    endtask

    task automatic wr(input int idx, input logic [7:0] d, input string req);
        op(1'b1, 1'b0, idx, d, req);
    endtask

    task automatic rd(input int idx, input string req);
        op(1'b0, 1'b1, idx, 8'h00, req);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): got hung run expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every index
        check("R1", {7'b0, irq}, 8'h00);
        for (int i = 0; i < 16; i++) rd(i, "R1");
        check("R1 rev", model_rd(14), 8'h04);

        // R2 / R3: bank separation and counter reload
        wr(0, 8'h34, "R2");
        wr(1, 8'h12, "R2");
        rd(0, "R2");
        rd(1, "R2");
        wr(3, 8'h80, "R3");
        rd(0, "R3");
        rd(1, "R3");
        rd(3, "R2");

        // R6 / R5: bus reset, unmasked then masked
        wr(3, 8'h03, "R6");
        rd(5, "R6");
        rd(5, "R5");
        wr(8, 8'h40, "R6");
        wr(3, 8'h03, "R6");
        rd(5, "R6");
        wr(8, 8'h00, "R6");

        // R10: FIFO fill past depth, drain, empty read
        for (int i = 0; i < FDEPTH + 2; i++) wr(2, 8'(8'hA0 + i), "R10");
        for (int i = 0; i < FDEPTH + 1; i++) rd(2, "R10");
        rd(5, "R5");
        rd(2, "R10");

        // R7: flush keeps irq, empties FIFO
        wr(2, 8'h55, "R7");
        wr(3, 8'h01, "R7");
        rd(2, "R7");
        rd(5, "R7");

        // R9: absent, present and ID 7 selection
        wr(4, 8'h01, "R9");
        wr(3, 8'h41, "R9");
        rd(4, "R9"); rd(5, "R9"); rd(6, "R9");
        wr(4, 8'h00, "R9");
        wr(3, 8'h41, "R9");
        rd(4, "R9"); rd(6, "R9"); rd(5, "R11");
        wr(4, 8'h07, "R9");
        wr(3, 8'h41, "R9");
        rd(5, "R9"); rd(4, "R5");

        // R4 / R12: present selection sets TC, NOP clears it only
        wr(4, 8'h05, "R4");
        wr(3, 8'h41, "R4");
        rd(4, "R4");
        wr(3, 8'h00, "R12");
        rd(4, "R4"); rd(5, "R12"); rd(6, "R12");
        wr(3, 8'h7E, "R12");
        rd(4, "R12"); rd(3, "R12");

        // R11: irq level held across unrelated traffic
        wr(3, 8'h03, "R11");
        wr(9, 8'hFF, "R11");
        rd(4, "R11");

        // R8: chip reset with DMA flag and filled FIFO
        wr(2, 8'h11, "R8");
        wr(0, 8'hEE, "R8");
        wr(3, 8'h82, "R8");
        rd(0, "R8"); rd(2, "R8"); rd(14, "R8"); rd(5, "R8");

        // constrained random traffic, R1 low address bits randomised
        void'($urandom(32'h5C51));
        for (int n = 0; n < 3000; n++) begin
            int         kind;
            int         idx;
            logic [7:0] d;
            logic [1:0] lo;
            kind = $urandom_range(0, 9);
            idx  = $urandom_range(0, 15);
            d    = 8'($urandom());
            lo   = 2'($urandom());
            if (kind < 4) begin
                op(1'b0, 1'b1, idx, 8'h00, "R1 R5 R10 random", lo);
            end else if (kind < 7) begin
                op(1'b1, 1'b0, idx, d, "R2 R10 random", lo);
            end else begin
                case ($urandom_range(0, 15))
                    0:          d[6:0] = 7'h02;
                    1, 2:       d[6:0] = 7'h01;
                    3, 4, 5:    d[6:0] = 7'h03;
                    6, 7, 8, 9: d[6:0] = 7'h41;
                    10, 11:     d[6:0] = 7'h00;
                    default:    ;
                endcase
                op(1'b1, 1'b0, 3, d, "R3 R4 R6 R8 R9 R12 random", lo);
            end
        end

        finish_run();
    end

endmodule